// File: doc/BRIEF.md
# Multiplexed-Address Flash Bus Front End

This block sits on the device side of a byte-wide, 1M x 8 flash. The host supplies a 20-bit byte address over 11 shared pins, in two phases. A row/column strobe picks the phase: the low 11 address bits are taken when the strobe falls, and the upper 9 bits are taken when it rises. The block assembles the full address and decodes which of sixteen 64 KB blocks it falls in. On a write strobe it takes the data byte as a command for a small placeholder command interpreter. A read with output enable returns a byte from a small behavioural store.

Program and erase requests pass two gates before they start:

- **Programming-voltage gate.** The request is refused when the programming voltage is reported below lockout.
- **Write-protect gate.** The request is refused when write protect is on and the target is any block other than the top one.

A refused request sets a status error bit and leaves ready/busy high. An accepted request drives ready/busy low for a parameterised number of cycles. While busy, the only command honoured is suspend. Suspend raises ready/busy at once and freezes the busy counter until resume.

The behavioural store holds 2^ARR_AW bytes, indexed by the low address bits and aliased across every block. It resets to all ones. Program clears bits, so the new byte is the old byte AND the data. Erase sets every entry to FF. Timing is counted in clock cycles.

Top module: `mux_flash_front`

## Requirements
- R1: On a clock where `rc_sel` was 1 and is now 0, `addr_pins` becomes address bits 10:0. On a clock where it was 0 and is now 1, `addr_pins[8:0]` becomes bits 19:11. The block number is bits 19:16, and block 15 is the top block.
- R2: With `rd_en` high, `dout` shows the store byte at address bits ARR_AW-1:0. With `rd_en` low, `dout` is 8'h00.
- R3: Writing command 8'h40 and then a data byte starts a program. `ready` is low for exactly PROG_CYC cycles, after which the addressed byte equals its old value AND the data.
- R4: Writing command 8'h20 starts an erase. `ready` is low for exactly ERASE_CYC cycles, after which every store byte reads 8'hFF.
- R5: With `wp_en` high, a program or erase aimed at blocks 0 to 14 is refused. `ready` stays high, the store is unchanged, and `status[4]` is set.
- R6: `wp_en` has no effect on a program or erase aimed at block 15.
- R7: With `vpp_ok` low, a program or erase is refused. `ready` stays high, the store is unchanged, and `status[3]` is set.
- R8: While busy and not suspended, every write other than 8'hB0 is ignored. It sets no error bit and does not change the running operation's length or result.
- R9: Writing 8'hB0 while busy sets `ready` and `status[6]` on the next clock and freezes the operation. Writing 8'hD0 resumes it with the cycles it had left.
- R10: `wp_en` is only examined when an operation starts. Changing it while busy does not stop the operation.
- R11: Reset aborts any operation and returns to read mode. After reset, `ready` is 1, `status` is 8'h80 and the store reads 8'hFF.
- R12: `status[7]` mirrors `ready`. Writing 8'h50 in read mode clears `status[4]` and `status[3]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power valid) |
| addr_pins | input | ROW_W | Shared row/column address pins |
| rc_sel | input | 1 | Row/column strobe: fall takes the row, rise takes the column |
| wr_en | input | 1 | One-cycle bus write strobe |
| rd_en | input | 1 | Output enable for bus reads |
| din | input | 8 | Write data / command byte |
| dout | output | 8 | Read data |
| wp_en | input | 1 | Write protect for blocks other than the top block |
| vpp_ok | input | 1 | Programming voltage above lockout |
| ready | output | 1 | Ready/busy: 0 while an operation runs |
| status | output | 8 | Status byte: bit 7 ready, bit 6 suspended, bit 4 protect error, bit 3 voltage error |

## Verification
On every cycle, the assertions check the following:

- Ready/busy can only fall when the programming voltage was good.
- Ready/busy can only fall with write protect set when the target was the top block.
- A protect error never appears while busy.
- Writes made during a busy interval raise no error bit.
- Suspend raises ready on the next clock.
- The counter holds still while suspended.

Only the bench's scenarios can show the rest:

- The exact length of the busy interval.
- The AND rule for program and the all-ones result of erase.
- That refused and ignored requests leave the store unchanged.
- That a resumed operation finishes with exactly the cycles it had left.
- That a reset mid-erase restores read mode.

// File: rtl/mxf_pkg.sv
package mxf_pkg;
    typedef enum logic [1:0] {
        ST_READ  = 2'd0,
        ST_PDATA = 2'd1,
        ST_BUSY  = 2'd2,
        ST_SUSP  = 2'd3
    } mxf_state_e;

    localparam logic [7:0] CMD_PROG   = 8'h40;
    localparam logic [7:0] CMD_ERASE  = 8'h20;
    localparam logic [7:0] CMD_SUSP   = 8'hB0;
    localparam logic [7:0] CMD_RESUME = 8'hD0;
    localparam logic [7:0] CMD_CLR    = 8'h50;

    localparam int SB_READY = 7;
    localparam int SB_SUSP  = 6;
    localparam int SB_PROT  = 4;
    localparam int SB_VPP   = 3;
endpackage

// File: rtl/mxf_addr_cap.sv
module mxf_addr_cap #(
    parameter int ROW_W = 11,
    parameter int COL_W = 9,
    localparam int AW = ROW_W + COL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] pins,
    input  logic             rc,
    output logic [AW-1:0]    addr
);
    typedef struct packed {
        logic             rc;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d    = cap_q;
        cap_d.rc = rc;
        if (cap_q.rc && !rc) cap_d.row = pins;
        if (!cap_q.rc && rc) cap_d.col = pins[COL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '{rc: 1'b1, row: '0, col: '0};
        else        cap_q <= cap_d;
    end

    assign addr = {cap_q.col, cap_q.row};
endmodule

// File: rtl/mxf_blk_dec.sv
module mxf_blk_dec #(
    parameter int AW    = 20,
    parameter int BLK_W = 4
) (
    input  logic [AW-1:0]    addr,
    output logic [BLK_W-1:0] blk,
    output logic             is_top
);
    assign blk    = addr[AW-1 -: BLK_W];
    assign is_top = &blk;
endmodule

// File: rtl/mxf_ctrl.sv
module mxf_ctrl
    import mxf_pkg::*;
#(
    parameter int AW        = 20,
    parameter int ARR_AW    = 4,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 40,
    localparam int DEPTH = 1 << ARR_AW,
    localparam int CW    = $clog2(ERASE_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          is_top,
    input  logic          we,
    input  logic [7:0]    din,
    input  logic          oe,
    input  logic          wp_en,
    input  logic          vpp_ok,
    output logic [7:0]    dout,
    output logic          ready,
    output logic [7:0]    status,
    output logic [CW-1:0] cnt,
    output logic          suspended
);
    typedef struct packed {
        mxf_state_e              st;
        logic                    erase;
        logic [ARR_AW-1:0]       op_idx;
        logic [7:0]              op_data;
        logic [CW-1:0]           cnt;
        logic                    err_prot;
        logic                    err_vpp;
        logic [DEPTH-1:0][7:0]   mem;
    } ctl_t;

    ctl_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_READ: if (we) begin
                if (din == CMD_PROG) r_d.st = ST_PDATA;
                else if (din == CMD_CLR) begin
                    r_d.err_prot = 1'b0;
                    r_d.err_vpp  = 1'b0;
                end else if (din == CMD_ERASE) begin
                    if (!vpp_ok)               r_d.err_vpp  = 1'b1;
                    else if (wp_en && !is_top) r_d.err_prot = 1'b1;
                    else begin
                        r_d.st    = ST_BUSY;
                        r_d.erase = 1'b1;
                        r_d.cnt   = CW'(ERASE_CYC - 1);
                    end
                end
            end
            ST_PDATA: if (we) begin
                r_d.st = ST_READ;
                if (!vpp_ok)               r_d.err_vpp  = 1'b1;
                else if (wp_en && !is_top) r_d.err_prot = 1'b1;
                else begin
                    r_d.st      = ST_BUSY;
                    r_d.erase   = 1'b0;
                    r_d.op_idx  = addr[ARR_AW-1:0];
                    r_d.op_data = din;
                    r_d.cnt     = CW'(PROG_CYC - 1);
                end
            end
            ST_BUSY: begin
                if (we && din == CMD_SUSP) r_d.st = ST_SUSP;
                else if (r_q.cnt == '0) begin
                    r_d.st = ST_READ;
                    if (r_q.erase) begin
                        for (int i = 0; i < DEPTH; i++) r_d.mem[i] = 8'hFF;
                    end else begin
                        r_d.mem[r_q.op_idx] = r_q.mem[r_q.op_idx] & r_q.op_data;
                    end
                end else r_d.cnt = r_q.cnt - 1'b1;
            end
            ST_SUSP: if (we && din == CMD_RESUME) r_d.st = ST_BUSY;
            default: r_d.st = ST_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= ST_READ;
            r_q.erase    <= 1'b0;
            r_q.op_idx   <= '0;
            r_q.op_data  <= '0;
            r_q.cnt      <= '0;
            r_q.err_prot <= 1'b0;
            r_q.err_vpp  <= 1'b0;
            for (int i = 0; i < DEPTH; i++) r_q.mem[i] <= 8'hFF;
        end else begin
            r_q <= r_d;
        end
    end

    assign ready     = (r_q.st != ST_BUSY);
    assign suspended = (r_q.st == ST_SUSP);
    assign cnt       = r_q.cnt;
    assign dout      = oe ? r_q.mem[addr[ARR_AW-1:0]] : 8'h00;

    always_comb begin
        status           = 8'h00;
        status[SB_READY] = ready;
        status[SB_SUSP]  = suspended;
        status[SB_PROT]  = r_q.err_prot;
        status[SB_VPP]   = r_q.err_vpp;
    end
endmodule

// File: rtl/mux_flash_front.sv
module mux_flash_front #(
    parameter int ROW_W     = 11,
    parameter int COL_W     = 9,
    parameter int BLK_W     = 4,
    parameter int ARR_AW    = 4,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] addr_pins,
    input  logic             rc_sel,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [7:0]       din,
    output logic [7:0]       dout,
    input  logic             wp_en,
    input  logic             vpp_ok,
    output logic             ready,
    output logic [7:0]       status
);
    localparam int AW    = ROW_W + COL_W;
    localparam int CNT_W = $clog2(ERASE_CYC + 1);

    logic [AW-1:0]    full_addr;
    logic [BLK_W-1:0] blk;
    logic             is_top;
    logic [CNT_W-1:0] cnt;
    logic             suspended;

    mxf_addr_cap #(.ROW_W(ROW_W), .COL_W(COL_W)) i_cap (
        .clk(clk), .rst_n(rst_n), .pins(addr_pins), .rc(rc_sel), .addr(full_addr)
    );

    mxf_blk_dec #(.AW(AW), .BLK_W(BLK_W)) i_dec (
        .addr(full_addr), .blk(blk), .is_top(is_top)
    );

    mxf_ctrl #(.AW(AW), .ARR_AW(ARR_AW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(full_addr), .is_top(is_top),
        .we(wr_en), .din(din), .oe(rd_en), .wp_en(wp_en), .vpp_ok(vpp_ok),
        .dout(dout), .ready(ready), .status(status), .cnt(cnt), .suspended(suspended)
    );
endmodule

// File: rtl/mxf_checker.sv
module mxf_checker #(
    parameter int BLK_W     = 4,
    parameter int CW        = 6,
    parameter int ERASE_CYC = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             we,
    input logic [7:0]       din,
    input logic             wp_en,
    input logic             vpp_ok,
    input logic             ready,
    input logic [7:0]       status,
    input logic [BLK_W-1:0] blk,
    input logic [CW-1:0]    cnt,
    input logic             suspended
);
    AST_START_NEEDS_VPP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(vpp_ok) && $past(we)); // R7

    AST_WP_TOP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ready) && $past(wp_en)) |-> ($past(blk) == {BLK_W{1'b1}})); // R6

    AST_PROT_ERR_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[4]) |-> ready); // R5

    AST_BUSY_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && we) |=> !$rose(status[4]) && !$rose(status[3])); // R8

    AST_SUSPEND_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && we && din == 8'hB0) |=> ready && status[6]); // R9

    AST_FROZEN_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && !(we && din == 8'hD0)) |=> $stable(cnt) && suspended); // R9

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(ERASE_CYC)); // R4

    AST_READY_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        status[7] == ready); // R12
endmodule

bind mux_flash_front mxf_checker #(.BLK_W(BLK_W), .CW(CNT_W), .ERASE_CYC(ERASE_CYC)) i_chk (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .din(din), .wp_en(wp_en), .vpp_ok(vpp_ok),
    .ready(ready), .status(status), .blk(blk), .cnt(cnt), .suspended(suspended)
);

// File: tb/test_mux_flash_front.sv
module test_mux_flash_front;
    localparam int PROG_CYC  = 8;
    localparam int ERASE_CYC = 40;
    localparam int ARR_AW    = 4;
    localparam int DEPTH     = 1 << ARR_AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] addr_pins = '0;
    logic        rc_sel = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        wp_en = 1'b0;
    logic        vpp_ok = 1'b1;
    logic        ready;
    logic [7:0]  status;

    int total = 0;
    int bad = 0;
    logic [7:0] model [DEPTH];

    always #4 clk = ~clk;

    mux_flash_front #(.ARR_AW(ARR_AW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) i_mux_flash_front (
        .clk(clk), .rst_n(rst_n), .addr_pins(addr_pins), .rc_sel(rc_sel), .wr_en(wr_en),
        .rd_en(rd_en), .din(din), .dout(dout), .wp_en(wp_en), .vpp_ok(vpp_ok),
        .ready(ready), .status(status)
    );

    function automatic logic refused(logic [19:0] a, logic wp, logic vp);
        return !vp || (wp && a[19:16] != 4'hF);
    endfunction

    function automatic logic [7:0] exp_status(logic [19:0] a, logic wp, logic vp);
        if (!vp) return 8'h88;
        if (wp && a[19:16] != 4'hF) return 8'h90;
        return 8'h80;
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_addr(input logic [19:0] a);
        @(negedge clk);
        addr_pins = a[10:0];
        rc_sel = 1'b0;
        @(negedge clk);
        addr_pins = {2'b00, a[19:11]};
        rc_sel = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] b);
        wr_en = 1'b1;
        din = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ready && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic rd(output logic [7:0] b);
        rd_en = 1'b1;
        #1 b = dout;
        rd_en = 1'b0;
    endtask

    task automatic reset_model();
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    endtask

    task automatic do_prog(input logic [19:0] a, input logic [7:0] d, input string tag);
        int n;
        logic [7:0] b;
        logic rf;
        rf = refused(a, wp_en, vpp_ok);
        set_addr(a);
        wr(8'h40);
        wr(d);
        wait_ready(n);
        check(n == (rf ? 0 : PROG_CYC), {tag, " busy cycles"}, n, rf ? 0 : PROG_CYC);
        check(status == exp_status(a, wp_en, vpp_ok), {tag, " status"}, status, exp_status(a, wp_en, vpp_ok));
        if (!rf) model[a[ARR_AW-1:0]] = model[a[ARR_AW-1:0]] & d;
        rd(b);
        check(b == model[a[ARR_AW-1:0]], {tag, " data"}, b, model[a[ARR_AW-1:0]]);
        if (status != 8'h80) wr(8'h50);
    endtask

    initial begin
        #200000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        logic [7:0] b;
        logic [19:0] a;
        void'($urandom(32'd1234));
        reset_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check(ready == 1'b1, "R11 ready after reset", ready, 1);
        check(status == 8'h80, "R11 status after reset", status, 8'h80);
        // R2 output disabled
        #1 check(dout == 8'h00, "R2 dout with rd_en low", dout, 0);
        rd(b);
        check(b == 8'hFF, "R2 erased read", b, 8'hFF);

        // R1 R3 program top block
        do_prog(20'hF0003, 8'h5A, "R3 program");
        do_prog(20'hF0003, 8'h0F, "R3 and-rule");
        // R1 different index remains erased
        set_addr(20'hF0007);
        rd(b);
        check(b == 8'hFF, "R1 row bits select index", b, 8'hFF);

        // R5 protected block
        wp_en = 1'b1;
        set_addr(20'h30005);
        wr(8'h40);
        wr(8'h00);
        check(ready == 1'b1, "R5 ready stays high", ready, 1);
        check(status == 8'h90, "R5 protect error", status, 8'h90);
        rd(b);
        check(b == 8'hFF, "R5 store unchanged", b, 8'hFF);
        wr(8'h50);
        check(status == 8'h80, "R12 clear status", status, 8'h80);

        // R1 column bits decide protection: 0x7xxxx vs 0xFxxxx at same row
        do_prog(20'hF0005, 8'h33, "R6 top block with wp");
        do_prog(20'h70006, 8'h11, "R1 column decode block 7");

        // R7 voltage lockout
        wp_en = 1'b0;
        vpp_ok = 1'b0;
        do_prog(20'hF0008, 8'h00, "R7 vpp lockout");
        set_addr(20'h10000);
        wr(8'h20);
        check(status == 8'h88 && ready, "R7 erase refused", status, 8'h88);
        wr(8'h50);
        vpp_ok = 1'b1;

        // R4 R8 erase with ignored writes
        wr(8'h20);
        check(ready == 1'b0, "R4 erase started", ready, 0);
        wr(8'h40);
        wr(8'h00);
        wr(8'h50);
        wait_ready(n);
        check(n == ERASE_CYC - 3, "R8 erase length unchanged", n, ERASE_CYC - 3);
        check(status == 8'h80, "R8 no error from busy writes", status, 8'h80);
        reset_model();
        set_addr(20'hF0003);
        rd(b);
        check(b == 8'hFF, "R4 erased byte", b, 8'hFF);
        // R8 the ignored 0x40 did not leave program pending
        wr(8'h00);
        check(ready == 1'b1, "R8 no pending program", ready, 1);

        // R9 suspend and resume
        set_addr(20'hF0002);
        wr(8'h40);
        wr(8'h3C);
        repeat (3) @(negedge clk);
        wr(8'hB0);
        check(ready == 1'b1 && status[6], "R9 suspend raises ready", status, 8'hC0);
        repeat (10) @(negedge clk);
        check(ready == 1'b1, "R9 stays suspended", ready, 1);
        wr(8'h40);
        check(status == 8'hC0, "R9 program refused in suspend", status, 8'hC0);
        rd(b);
        check(b == 8'hFF, "R9 store frozen", b, 8'hFF);
        wr(8'hD0);
        wait_ready(n);
        check(n == PROG_CYC - 3, "R9 remaining cycles", n, PROG_CYC - 3);
        model[2] = 8'h3C;
        rd(b);
        check(b == 8'h3C, "R9 completes after resume", b, 8'h3C);

        // R10 wp change during busy
        set_addr(20'h20009);
        wr(8'h40);
        wr(8'hA5);
        wp_en = 1'b1;
        wait_ready(n);
        check(n == PROG_CYC, "R10 op completes", n, PROG_CYC);
        model[9] = 8'hA5;
        rd(b);
        check(b == 8'hA5, "R10 data written", b, 8'hA5);
        wp_en = 1'b0;

        // R11 reset aborts erase
        wr(8'h20);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        reset_model();
        check(ready == 1'b1 && status == 8'h80, "R11 abort by reset", status, 8'h80);
        set_addr(20'hF0009);
        rd(b);
        check(b == 8'hFF, "R11 store reset", b, 8'hFF);

        // random mix: R3 R5 R6 R7
        for (int k = 0; k < 40; k++) begin
            a = $urandom();
            if ($urandom_range(0, 1) == 0) a[19:16] = 4'hF;
            wp_en = 1'($urandom_range(0, 1));
            vpp_ok = ($urandom_range(0, 5) != 0);
            do_prog(a, 8'($urandom()), "R3 R5 R6 R7 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule